// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Thresholds

This block sits between a serial audio engine and the system bus. It holds two 32-entry sample queues. The transmit queue is filled by bus writes and drained by the serial engine. The receive queue is filled by the serial engine and drained by bus reads. Both queues share one data address: a write there pushes a transmit sample, and a read there pops a receive sample. Toward the serial engine each queue is a valid/ready stream. A transfer happens on a clock edge where both valid and ready are high. The transmit stream holds its word steady while it is stalled. The receive stream withholds ready while its queue is full.

Each queue has its own control word. The control word flushes the queue, gates a DMA request and sets a 4-bit level threshold. The DMA request tells an external controller when a burst of up to 16 words can be moved. Bus misuse sets bits in a 7-bit sticky status register. A bus write to a full transmit queue is one such misuse, and a bus read from an empty receive queue is the other. Each status bit is cleared by writing a one to it, and an enable mask routes the status bits to one interrupt line.

Top module: `snd_fifo_pair`

## Requirements
- R1: After reset, both queues are empty, so tx_m_valid=0 and rx_s_ready=1. Both DMA requests and irq are 0, and the registers at 0x0C, 0x10, 0x1C and 0x20 read 0.
- R2: A write to offset 0x24 pushes reg_wdata into the transmit queue. Words leave on tx_m_data in push order. While tx_m_valid=1 and tx_m_ready=0, tx_m_valid stays 1 and tx_m_data stays unchanged.
- R3: rx_s_ready is 1 exactly when the receive queue holds fewer than 32 words. A read of 0x24 pops the oldest received word, and reg_rdata shows it in the cycle after the read strobe.
- R4: The control words are at 0x0C (transmit) and 0x10 (receive). Bit 1 is the DMA enable, bits 5:2 are the threshold and bit 0 is the flush. Bits 5:1 read back as written, and bit 0 always reads 0.
- R5: Writing a control word with bit 0 = 1 empties that queue by the next cycle and leaves the other queue untouched.
- R6: tx_dma_req = enable AND (32 − transmit level ≥ threshold).
- R7: rx_dma_req = enable AND (receive level ≥ threshold).
- R8: A write to 0x24 while the transmit queue is full is dropped and sets status bit 0. A read of 0x24 while the receive queue is empty returns 0 and sets status bit 1.
- R9: The status register is at 0x20 and is 7 bits wide. A written 1 clears that bit, and a written 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: The interrupt enable register is at 0x1C and is 7 bits wide. irq = OR over i of (status[i] AND enable[i]).
- R11: Reads of any offset other than 0x0C, 0x10, 0x1C, 0x20 and 0x24 return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| tx_m_valid | output | 1 | Transmit stream has a word |
| tx_m_ready | input | 1 | Serial engine takes the transmit word |
| tx_m_data | output | DATA_W | Transmit stream word |
| rx_s_valid | input | 1 | Serial engine offers a received word |
| rx_s_ready | output | 1 | Receive queue can accept a word |
| rx_s_data | input | DATA_W | Received word |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Masked status interrupt |

## Verification
Queue levels, control fields, status and the enable mask all change on the edge that samples a strobe or handshake. The outputs derived from them (stream valid and ready, DMA requests, irq) follow in the same cycle after that edge. Read data is registered and appears one cycle after its strobe. The bench drives inputs at falling edges, so each check made at the following falling edge sees exactly one rising edge after the stimulus. A read result is taken at the falling edge that ends the strobe.

// File: rtl/snd_fifo_pkg.sv
package snd_fifo_pkg;
  localparam int REG_W = 32;
  localparam int STS_W = 7;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_TXCTL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RXCTL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IE    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STS   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h24;

  localparam int STS_TXOVF = 0;
  localparam int STS_RXUNF = 1;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int CH_N  = 2;
endpackage

// File: rtl/snd_fifo_ring.sv
module snd_fifo_ring #(
  parameter int W = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/snd_fifo_ctl.sv
module snd_fifo_ctl
  import snd_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter bit IS_TX = 1'b1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [5:0]       wfield,
  input  logic [CW-1:0]    level,
  output logic             flush,
  output logic             dreq,
  output logic [REG_W-1:0] view
);
  logic       en;
  logic [3:0] thr;

  assign flush = wr_en && wfield[0];
  assign view  = REG_W'({thr, en, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      thr <= '0;
    end else if (wr_en) begin
      en  <= wfield[1];
      thr <= wfield[5:2];
    end
  end

  generate
    if (IS_TX) begin : g_space
      logic [CW-1:0] space;
      assign space = CW'(DEPTH) - level;
      assign dreq  = en && (space >= CW'(thr));
    end else begin : g_fill
      assign dreq  = en && (level >= CW'(thr));
    end
  endgenerate
endmodule

// File: rtl/snd_fifo_pair.sv
module snd_fifo_pair
  import snd_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              tx_m_valid,
  input  logic              tx_m_ready,
  output logic [DATA_W-1:0] tx_m_data,
  input  logic              rx_s_valid,
  output logic              rx_s_ready,
  input  logic [DATA_W-1:0] rx_s_data,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic hit_txc, hit_rxc, hit_ie, hit_sts, hit_data;
  assign hit_txc  = (reg_addr == OFS_TXCTL);
  assign hit_rxc  = (reg_addr == OFS_RXCTL);
  assign hit_ie   = (reg_addr == OFS_IE);
  assign hit_sts  = (reg_addr == OFS_STS);
  assign hit_data = (reg_addr == OFS_DATA);

  logic [CH_N-1:0]  ctl_wr, ctl_flush, ctl_dreq;
  logic [CW-1:0]    lvl [CH_N];
  logic [REG_W-1:0] ctl_view [CH_N];

  assign ctl_wr[CH_TX] = reg_wr && hit_txc;
  assign ctl_wr[CH_RX] = reg_wr && hit_rxc;

  generate
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ctl
      snd_fifo_ctl #(.DEPTH(DEPTH), .IS_TX(ch == CH_TX)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctl_wr[ch]),
        .wfield (reg_wdata[5:0]),
        .level  (lvl[ch]),
        .flush  (ctl_flush[ch]),
        .dreq   (ctl_dreq[ch]),
        .view   (ctl_view[ch])
      );
    end
  endgenerate

  assign tx_dma_req = ctl_dreq[CH_TX];
  assign rx_dma_req = ctl_dreq[CH_RX];

  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push, rx_pop;
  logic [DATA_W-1:0] rx_head;

  assign tx_push = reg_wr && hit_data;
  assign rx_pop  = reg_rd && hit_data;

  snd_fifo_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctl_flush[CH_TX]),
    .push  (tx_push),
    .din   (reg_wdata[DATA_W-1:0]),
    .pop   (tx_m_valid && tx_m_ready),
    .dout  (tx_m_data),
    .level (lvl[CH_TX]),
    .full  (tx_full),
    .empty (tx_empty)
  );

  snd_fifo_ring #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (ctl_flush[CH_RX]),
    .push  (rx_s_valid && rx_s_ready),
    .din   (rx_s_data),
    .pop   (rx_pop),
    .dout  (rx_head),
    .level (lvl[CH_RX]),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_m_valid = !tx_empty;
  assign rx_s_ready = !rx_full;

  logic [STS_W-1:0] sts, ie, sts_set, sts_clr;

  always_comb begin
    sts_set = '0;
    sts_set[STS_TXOVF] = tx_push && tx_full;
    sts_set[STS_RXUNF] = rx_pop && rx_empty;
    sts_clr = (reg_wr && hit_sts) ? reg_wdata[STS_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      ie  <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | sts_set;
      if (reg_wr && hit_ie) ie <= reg_wdata[STS_W-1:0];
    end
  end

  assign irq = |(sts & ie);

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_txc)  rd_mux = ctl_view[CH_TX];
    if (hit_rxc)  rd_mux = ctl_view[CH_RX];
    if (hit_ie)   rd_mux = 32'(ie);
    if (hit_sts)  rd_mux = 32'(sts);
    if (hit_data) rd_mux = rx_empty ? '0 : 32'(rx_head);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/snd_fifo_pair_chk.sv
module snd_fifo_pair_chk
  import snd_fifo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              tx_m_valid,
  input logic              tx_m_ready,
  input logic [DATA_W-1:0] tx_m_data,
  input logic              tx_dma_req,
  input logic              rx_dma_req,
  input logic              irq
);
  logic tx_flush_wr;
  assign tx_flush_wr = reg_wr && (reg_addr == OFS_TXCTL) && reg_wdata[0];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_m_valid && !tx_m_ready && !tx_flush_wr |=> tx_m_valid && $stable(tx_m_data)); // R2

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush_wr |=> !tx_m_valid); // R5

  AST_TX_DREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == OFS_TXCTL) && !reg_wdata[1] |=> !tx_dma_req); // R6

  AST_RX_DREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == OFS_RXCTL) && !reg_wdata[1] |=> !rx_dma_req); // R7

  AST_STS_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == OFS_STS) && (reg_wdata[STS_W-1:0] == '1) && !reg_rd |=> !irq); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (reg_addr == 8'h04) |=> reg_rdata == '0); // R11
endmodule

bind snd_fifo_pair snd_fifo_pair_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/snd_fifo_pair_test.sv
module snd_fifo_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_m_valid, tx_m_ready = 1'b0;
  logic [31:0] tx_m_data;
  logic        rx_s_valid = 1'b0, rx_s_ready;
  logic [31:0] rx_s_data = '0;
  logic        tx_dma_req, rx_dma_req, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  snd_fifo_pair uut (.*);

  // vector: {threshold[3:0], words[5:0], tx_req, rx_req}
  localparam logic [11:0] VEC [9] = '{
    {4'd8,  6'd0,  1'b1, 1'b0},
    {4'd8,  6'd8,  1'b1, 1'b1},
    {4'd8,  6'd24, 1'b1, 1'b1},
    {4'd8,  6'd25, 1'b0, 1'b1},
    {4'd15, 6'd17, 1'b1, 1'b1},
    {4'd15, 6'd18, 1'b0, 1'b1},
    {4'd15, 6'd14, 1'b1, 1'b0},
    {4'd0,  6'd0,  1'b1, 1'b1},
    {4'd4,  6'd32, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk);
    rx_s_valid = 1'b1; rx_s_data = d;
    @(negedge clk);
    rx_s_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 tx_m_valid", 32'(tx_m_valid), 0);
    check("R1 rx_s_ready", 32'(rx_s_ready), 1);
    check("R1 dma reqs", {30'd0, tx_dma_req, rx_dma_req}, 0);
    check("R1 irq", 32'(irq), 0);
    bus_read(8'h0C, v); check("R1 txctl", v, 0);
    bus_read(8'h10, v); check("R1 rxctl", v, 0);
    bus_read(8'h1C, v); check("R1 ie", v, 0);
    bus_read(8'h20, v); check("R1 status", v, 0);

    // R4 readback, flush bit reads 0
    bus_write(8'h10, 32'h26); bus_read(8'h10, v); check("R4 rxctl readback", v, 32'h26);
    bus_write(8'h0C, 32'h27); bus_read(8'h0C, v); check("R4 flush bit reads 0", v, 32'h26);

    // table: R6 and R7 thresholds
    for (int i = 0; i < 9; i++) begin
      logic [3:0] thr;
      logic [5:0] n;
      thr = VEC[i][11:8];
      n   = VEC[i][7:2];
      bus_write(8'h0C, 32'({thr, 2'b11}));
      bus_write(8'h10, 32'({thr, 2'b11}));
      for (int k = 0; k < int'(n); k++) begin
        bus_write(8'h24, 32'(i * 100 + k));
        rx_push(32'(i * 100 + k));
      end
      @(negedge clk);
      check($sformatf("R6 vec%0d tx_dma_req", i), 32'(tx_dma_req), 32'(VEC[i][1]));
      check($sformatf("R7 vec%0d rx_dma_req", i), 32'(rx_dma_req), 32'(VEC[i][0]));
    end

    // flush both, disable DMA
    bus_write(8'h0C, 32'h1);
    bus_write(8'h10, 32'h1);
    check("R5 tx empty after flush", 32'(tx_m_valid), 0);
    check("R5 rx ready after flush", 32'(rx_s_ready), 1);

    // R2 ordering and back-pressure
    bus_write(8'h24, 32'hA1);
    bus_write(8'h24, 32'hB2);
    bus_write(8'h24, 32'hC3);
    repeat (3) @(negedge clk);
    check("R2 held valid", 32'(tx_m_valid), 1);
    check("R2 held data", tx_m_data, 32'hA1);
    tx_m_ready = 1'b1;
    @(negedge clk); check("R2 second word", tx_m_data, 32'hB2);
    @(negedge clk); check("R2 third word", tx_m_data, 32'hC3);
    @(negedge clk); tx_m_ready = 1'b0;
    check("R2 drained", 32'(tx_m_valid), 0);

    // R3 receive pop order
    rx_push(32'hD4);
    rx_push(32'hE5);
    bus_read(8'h24, v); check("R3 first pop", v, 32'hD4);
    bus_read(8'h24, v); check("R3 second pop", v, 32'hE5);

    // R8 underflow, R10 masking, R9 clear
    bus_read(8'h24, v); check("R8 underflow data", v, 0);
    bus_read(8'h20, v); check("R8 underflow status", v, 32'h2);
    check("R10 masked irq", 32'(irq), 0);
    bus_write(8'h1C, 32'h2); check("R10 irq on", 32'(irq), 1);
    bus_write(8'h1C, 32'h1); check("R10 irq off other mask", 32'(irq), 0);
    bus_write(8'h20, 32'h0); bus_read(8'h20, v); check("R9 zero write keeps", v, 32'h2);
    bus_write(8'h20, 32'h2); bus_read(8'h20, v); check("R9 one clears", v, 0);

    // R8 overflow: 33 writes into 32 entries
    for (int k = 0; k < 33; k++) bus_write(8'h24, 32'(16'h100 + k));
    bus_read(8'h20, v); check("R8 overflow status", v, 32'h1);
    check("R8 irq via enable bit0", 32'(irq), 1);
    check("R8 head kept", tx_m_data, 32'h100);
    bus_write(8'h0C, 32'h6);
    check("R6 full queue no request", 32'(tx_dma_req), 0);
    bus_write(8'h20, 32'h7F);

    // R5 isolation: flushing receive leaves transmit alone
    rx_push(32'hF6);
    bus_write(8'h10, 32'h1);
    check("R5 tx untouched valid", 32'(tx_m_valid), 1);
    check("R5 tx untouched data", tx_m_data, 32'h100);
    bus_read(8'h24, v); check("R5 rx flushed", v, 0);
    bus_read(8'h20, v); check("R5 rx flushed underflow", v, 32'h2);
    bus_write(8'h0C, 32'h1);
    check("R5 tx flushed", 32'(tx_m_valid), 0);

    // R3 receive full back-pressure
    for (int k = 0; k < 32; k++) rx_push(32'(k));
    check("R3 full not ready", 32'(rx_s_ready), 0);
    bus_read(8'h24, v); check("R3 oldest after fill", v, 0);
    check("R3 ready after pop", 32'(rx_s_ready), 1);

    // R11 unmapped
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, v); check("R11 unmapped 04", v, 0);
    bus_read(8'h44, v); check("R11 unmapped 44", v, 0);
    bus_read(8'h0C, v); check("R11 ctl unaffected", v, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule